// File: doc/BRIEF.md
# Shared Interrupt Pin Router

This block sits after the masking stage of a shared interrupt controller. It receives one pending bit per shared source and decides which processor contexts see each source and on which of their lines. Every processor context has a vector of numbered interrupt pins, one non-maskable interrupt (NMI) line and one debug line. For each source, software programs a route word and a multi-hot processor selection. The route word holds three enables (numbered pin, NMI, debug) and a pin number.

All routing registers sit behind a plain 32-bit register port. A write takes a write strobe, a byte address and data. Reads are combinational from the address. A source is delivered to every selected processor on every enabled kind of line at once, and lines with several contributors see the OR of them. The outputs are registered, so the lines follow the pending inputs one clock later.

Top module: `irq_pin_router`

## Requirements
- R1: While reset is low and on the first cycle after it, every pin, NMI and debug output is 0. Every route word and selection word reads 0, so no source is routed after reset.
- R2: The route word of source n is at byte address MAP_BASE + 4*n. Bit 31 enables the numbered pin, bit 30 enables NMI, bit 29 enables debug, and bits 5:0 give the pin number. A read returns those nine bits as last written, with all other bits 0.
- R3: Processor selection word w of source n is at SEL_BASE + 32*n + 4*w. Processor v is bit v%32 of word v/32. Bits for processor numbers at or above NUM_CPU are not stored and read 0.
- R4: Pin k of processor p is driven when a pending source has bit p of its selection set, its pin enable set and its pin number equal to k. The pin outputs are packed as index p*NUM_PIN + k.
- R5: The NMI line of processor p is driven when a pending source has its NMI enable set and processor p selected, whatever its pin enable.
- R6: The debug line of processor p is driven when a pending source has its debug enable set and processor p selected.
- R7: One source drives every processor it selects at the same time. Several sources that reach the same line combine as an OR.
- R8: A pin number at or above NUM_PIN drives no pin output. The NMI and debug routing of that source still applies.
- R9: Each output reflects the pending inputs and routing registers sampled at the previous rising clock edge: exactly one cycle of latency, for both assertion and release.
- R10: Writes to an address outside the two register ranges, to a selection word index at or above ceil(NUM_CPU/32), or with address bits 1:0 nonzero change no register. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| src_pend | input | NUM_SRC | Masked pending bit per shared source |
| cpu_pin | output | NUM_CPU*NUM_PIN | Numbered interrupt pins, bit p*NUM_PIN+k is pin k of processor p |
| cpu_nmi | output | NUM_CPU | NMI line per processor |
| cpu_dbg | output | NUM_CPU | Debug line per processor |

## Verification
The bench builds the router with NUM_SRC=5, NUM_CPU=34 and NUM_PIN=6. With five sources, which is not a power of two, the decoder must turn away route indices 5 to 7 even though the index field can encode them. With 34 processors a second selection word exists but holds only two live bits, so the word split and the dropping of bits above NUM_CPU can both be observed. With six pins, pin numbers 6 to 63 fall out of range, which exercises the out-of-range case. The 5-bit and 34-bit widths also check that packed-index arithmetic does not assume power-of-two sizes.

// File: rtl/irq_router_pkg.sv
// Package: irq_router_pkg
// Shared field positions and the stored route record for the pin router.
// Assumes 32-bit register words and a 6-bit pin number field.
package irq_router_pkg;

    localparam int WORD_W           = 32;
    localparam int MAP_PIN_EN_BIT   = 31;
    localparam int MAP_NMI_EN_BIT   = 30;
    localparam int MAP_DBG_EN_BIT   = 29;
    localparam int PIN_NUM_W        = 6;
    localparam int MAP_STRIDE_BYTES = 4;
    localparam int SEL_STRIDE_BYTES = 32;

    // Stored part of one route word; the other bits are not kept.
    typedef struct packed {
        logic                 pin_en;
        logic                 nmi_en;
        logic                 dbg_en;
        logic [PIN_NUM_W-1:0] pin_num;
    } route_word_t;

endpackage

// File: rtl/irq_route_regs.sv
// Module: irq_route_regs
// Holds the per-source route words and processor selection bits, and
// decodes the 32-bit register port for writes and combinational reads.
// Assumes NUM_CPU <= 256 (at most 8 selection words per source) and that
// the two address ranges do not overlap.
module irq_route_regs
    import irq_router_pkg::*;
#(
    parameter int              NUM_SRC  = 8,
    parameter int              NUM_CPU  = 4,
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] MAP_BASE = 16'h0000,
    parameter logic [ADDR_W-1:0] SEL_BASE = 16'h1000
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [WORD_W-1:0]                 bus_wdata,
    output logic [WORD_W-1:0]                 bus_rdata,
    output route_word_t [NUM_SRC-1:0]         route_o,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   sel_o
);

    localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int SEL_WORDS = (NUM_CPU + WORD_W - 1) / WORD_W;
    localparam int MAP_SPAN  = MAP_STRIDE_BYTES * NUM_SRC;
    localparam int SEL_SPAN  = SEL_STRIDE_BYTES * NUM_SRC;

    route_word_t [NUM_SRC-1:0]       route_q, route_d;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] sel_q, sel_d;

    logic [ADDR_W-1:0] off_map, off_sel;
    logic              aligned, map_hit, sel_hit;
    logic [SRC_W-1:0]  map_idx, sel_src;
    logic [2:0]        sel_word;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[MAP_DBG_EN_BIT-1:PIN_NUM_W];

    // Address decode: offsets into each range, hit flags and indices.
    always_comb begin
        off_map  = bus_addr - MAP_BASE;
        off_sel  = bus_addr - SEL_BASE;
        aligned  = (bus_addr[1:0] == 2'b00);
        map_idx  = off_map[SRC_W+1:2];
        sel_src  = off_sel[SRC_W+4:5];
        sel_word = off_sel[4:2];
        map_hit  = aligned && (off_map < ADDR_W'(MAP_SPAN));
        sel_hit  = aligned && (off_sel < ADDR_W'(SEL_SPAN))
                   && ({29'd0, sel_word} < SEL_WORDS);
    end

    // Next-state for the storage: apply a decoded write, else hold.
    always_comb begin
        route_d = route_q;
        sel_d   = sel_q;
        if (bus_wr && map_hit) begin
            for (int n = 0; n < NUM_SRC; n++) begin
                if (map_idx == SRC_W'(n)) begin
                    route_d[n].pin_en  = bus_wdata[MAP_PIN_EN_BIT];
                    route_d[n].nmi_en  = bus_wdata[MAP_NMI_EN_BIT];
                    route_d[n].dbg_en  = bus_wdata[MAP_DBG_EN_BIT];
                    route_d[n].pin_num = bus_wdata[PIN_NUM_W-1:0];
                end
            end
        end
        if (bus_wr && sel_hit) begin
            for (int n = 0; n < NUM_SRC; n++) begin
                for (int v = 0; v < NUM_CPU; v++) begin
                    if (sel_src == SRC_W'(n) && sel_word == 3'(v / WORD_W)) begin
                        sel_d[n][v] = bus_wdata[v % WORD_W];
                    end
                end
            end
        end
    end

    // Storage registers, cleared by reset so nothing is routed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
            sel_q   <= '0;
        end else begin
            route_q <= route_d;
            sel_q   <= sel_d;
        end
    end

    // Read mux: route word or selection word, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (map_hit) begin
            for (int n = 0; n < NUM_SRC; n++) begin
                if (map_idx == SRC_W'(n)) begin
                    bus_rdata[MAP_PIN_EN_BIT]  = route_q[n].pin_en;
                    bus_rdata[MAP_NMI_EN_BIT]  = route_q[n].nmi_en;
                    bus_rdata[MAP_DBG_EN_BIT]  = route_q[n].dbg_en;
                    bus_rdata[PIN_NUM_W-1:0]   = route_q[n].pin_num;
                end
            end
        end else if (sel_hit) begin
            for (int n = 0; n < NUM_SRC; n++) begin
                for (int v = 0; v < NUM_CPU; v++) begin
                    if (sel_src == SRC_W'(n) && sel_word == 3'(v / WORD_W)) begin
                        bus_rdata[v % WORD_W] = sel_q[n][v];
                    end
                end
            end
        end
    end

    assign route_o = route_q;
    assign sel_o   = sel_q;

    // R10: a write that hits neither range leaves all storage unchanged.
    p_stray_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !map_hit && !sel_hit) |=> ($stable(route_q) && $stable(sel_q)));

endmodule

// File: rtl/irq_route_matrix.sv
// Module: irq_route_matrix
// Combines pending sources with their route words and processor selections
// into per-processor pin, NMI and debug lines, registered once.
// Assumes NUM_PIN <= 64 so every pin is reachable by the 6-bit field.
module irq_route_matrix
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CPU = 4,
    parameter int NUM_PIN = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SRC-1:0]                src_pend,
    input  route_word_t [NUM_SRC-1:0]         route_i,
    input  logic [NUM_SRC-1:0][NUM_CPU-1:0]   sel_i,
    output logic [NUM_CPU*NUM_PIN-1:0]        cpu_pin,
    output logic [NUM_CPU-1:0]                cpu_nmi,
    output logic [NUM_CPU-1:0]                cpu_dbg
);

    localparam int PIN_TOTAL = NUM_CPU * NUM_PIN;

    logic [PIN_TOTAL-1:0] pin_d;
    logic [NUM_CPU-1:0]   nmi_d, dbg_d;

    // OR every pending, selected source into its enabled lines.
    always_comb begin
        pin_d = '0;
        nmi_d = '0;
        dbg_d = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            for (int p = 0; p < NUM_CPU; p++) begin
                if (src_pend[n] && sel_i[n][p]) begin
                    if (route_i[n].nmi_en) nmi_d[p] = 1'b1;
                    if (route_i[n].dbg_en) dbg_d[p] = 1'b1;
                    if (route_i[n].pin_en) begin
                        for (int k = 0; k < NUM_PIN; k++) begin
                            if (route_i[n].pin_num == PIN_NUM_W'(k))
                                pin_d[p*NUM_PIN + k] = 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Output registers: one cycle from pending to the lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_pin <= '0;
            cpu_nmi <= '0;
            cpu_dbg <= '0;
        end else begin
            cpu_pin <= pin_d;
            cpu_nmi <= nmi_d;
            cpu_dbg <= dbg_d;
        end
    end

    // Per-kind enable vectors and per-processor selection columns for checks.
    logic [NUM_SRC-1:0]              pin_en_vec, nmi_en_vec, dbg_en_vec;
    logic [NUM_CPU-1:0][NUM_SRC-1:0] sel_col;

    always_comb begin
        for (int n = 0; n < NUM_SRC; n++) begin
            pin_en_vec[n] = route_i[n].pin_en;
            nmi_en_vec[n] = route_i[n].nmi_en;
            dbg_en_vec[n] = route_i[n].dbg_en;
            for (int p = 0; p < NUM_CPU; p++) sel_col[p][n] = sel_i[n][p];
        end
    end

    // R1: the first cycle after reset shows quiet outputs.
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cpu_pin == '0 && cpu_nmi == '0 && cpu_dbg == '0));

    // R9: no pending source in the previous cycle means no line now.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|src_pend) |-> (cpu_pin == '0 && cpu_nmi == '0 && cpu_dbg == '0));

    // R4: a pin line needs a pending source with its pin enable set.
    p_pin_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|cpu_pin) |-> $past(|(src_pend & pin_en_vec)));

    for (genvar p = 0; p < NUM_CPU; p++) begin : g_cpu_chk
        // R5: NMI on processor p needs an NMI-enabled source selecting p.
        p_nmi_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_nmi[p] |-> $past(|(src_pend & nmi_en_vec & sel_col[p])));
        // R6: debug on processor p needs a debug-enabled source selecting p.
        p_dbg_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_dbg[p] |-> $past(|(src_pend & dbg_en_vec & sel_col[p])));
    end

endmodule

// File: rtl/irq_pin_router.sv
// Module: irq_pin_router
// Top of the shared interrupt pin router: register block plus the
// registered routing matrix. Assumes src_pend is already masked and
// synchronous to clk.
module irq_pin_router
    import irq_router_pkg::*;
#(
    parameter int                NUM_SRC  = 8,
    parameter int                NUM_CPU  = 4,
    parameter int                NUM_PIN  = 6,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] MAP_BASE = 16'h0000,
    parameter logic [ADDR_W-1:0] SEL_BASE = 16'h1000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_SRC-1:0]         src_pend,
    output logic [NUM_CPU*NUM_PIN-1:0] cpu_pin,
    output logic [NUM_CPU-1:0]         cpu_nmi,
    output logic [NUM_CPU-1:0]         cpu_dbg
);

    route_word_t [NUM_SRC-1:0]       route_w;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] sel_w;

    // Register storage and bus decode.
    irq_route_regs #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CPU  (NUM_CPU),
        .ADDR_W   (ADDR_W),
        .MAP_BASE (MAP_BASE),
        .SEL_BASE (SEL_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .route_o   (route_w),
        .sel_o     (sel_w)
    );

    // Routing matrix with registered outputs.
    irq_route_matrix #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU),
        .NUM_PIN (NUM_PIN)
    ) u_matrix (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_pend (src_pend),
        .route_i  (route_w),
        .sel_i    (sel_w),
        .cpu_pin  (cpu_pin),
        .cpu_nmi  (cpu_nmi),
        .cpu_dbg  (cpu_dbg)
    );

endmodule

// File: tb/irq_pin_router_test.sv
// Scoreboard bench: the driver task pushes expected line states computed
// from a register model; the monitor pops one per rising edge and compares.
module irq_pin_router_test;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 5;
    localparam int NC = 34;
    localparam int NP = 6;
    localparam int AW = 16;
    localparam logic [AW-1:0] MAPB = 16'h0000;
    localparam logic [AW-1:0] SELB = 16'h1000;
    localparam int SELW = (NC + 31) / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] src_pend = '0;
    logic [NC*NP-1:0] cpu_pin;
    logic [NC-1:0] cpu_nmi, cpu_dbg;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [NC*NP-1:0] pin;
        logic [NC-1:0]    nmi;
        logic [NC-1:0]    dbg;
        string            tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t last_exp;

    logic [31:0]   map_m [NS];
    logic [NC-1:0] sel_m [NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pin_router #(
        .NUM_SRC (NS), .NUM_CPU (NC), .NUM_PIN (NP),
        .ADDR_W (AW), .MAP_BASE (MAPB), .SEL_BASE (SELB)
    ) uut (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .src_pend (src_pend),
        .cpu_pin (cpu_pin), .cpu_nmi (cpu_nmi), .cpu_dbg (cpu_dbg)
    );

    // Expected lines for a pending pattern, from R4-R8.
    function automatic exp_t model(logic [NS-1:0] pend, string tag);
        exp_t e;
        e.pin = '0; e.nmi = '0; e.dbg = '0; e.tag = tag;
        for (int n = 0; n < NS; n++)
            for (int p = 0; p < NC; p++)
                if (pend[n] && sel_m[n][p]) begin
                    if (map_m[n][30]) e.nmi[p] = 1'b1;
                    if (map_m[n][29]) e.dbg[p] = 1'b1;
                    if (map_m[n][31] && int'(map_m[n][5:0]) < NP)
                        e.pin[p*NP + int'(map_m[n][5:0])] = 1'b1;
                end
        return e;
    endfunction

    // Expected read value of an address, from R2, R3 and R10.
    function automatic logic [31:0] model_rd(logic [AW-1:0] a);
        logic [31:0] r = '0;
        int off;
        if (a[1:0] != 2'b00) return '0;
        if (a >= MAPB && int'(a - MAPB) < 4*NS) return map_m[int'(a - MAPB) / 4];
        if (a >= SELB && int'(a - SELB) < 32*NS) begin
            off = int'(a - SELB);
            if ((off % 32) / 4 >= SELW) return '0;
            for (int b = 0; b < 32; b++)
                if (((off % 32) / 4) * 32 + b < NC) r[b] = sel_m[off / 32][((off % 32) / 4) * 32 + b];
        end
        return r;
    endfunction

    function automatic void check_line(bit ok, string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endfunction

    function automatic void cmp_lines(exp_t e, string when);
        n_chk++;
        if (cpu_pin !== e.pin || cpu_nmi !== e.nmi || cpu_dbg !== e.dbg) begin
            n_fail++;
            $display("FAIL %s %s: actual pin=%h nmi=%h dbg=%h expected pin=%h nmi=%h dbg=%h",
                     e.tag, when, cpu_pin, cpu_nmi, cpu_dbg, e.pin, e.nmi, e.dbg);
        end
    endfunction

    // Monitor: one expectation per rising edge, compared after it settles.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp_lines(e, "after edge");
            last_exp = e;
        end
    end

    // Register write; model updated by the rules of R2, R3 and R10.
    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        int off;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        if (a[1:0] == 2'b00) begin
            if (a >= MAPB && int'(a - MAPB) < 4*NS)
                map_m[int'(a - MAPB) / 4] = d & 32'hE000_003F;
            else if (a >= SELB && int'(a - SELB) < 32*NS) begin
                off = int'(a - SELB);
                if ((off % 32) / 4 < SELW)
                    for (int b = 0; b < 32; b++)
                        if (((off % 32) / 4) * 32 + b < NC)
                            sel_m[off / 32][((off % 32) / 4) * 32 + b] = d[b];
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic check_read(logic [AW-1:0] a, logic [31:0] expv, string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        n_chk++;
        if (bus_rdata !== expv) begin
            n_fail++;
            $display("FAIL %s read %h: actual=%h expected=%h", req, a, bus_rdata, expv);
        end
    endtask

    // Driver: apply a pending pattern and queue what the next edge must show.
    // Before that edge the lines must still show the previous result (R9).
    task automatic apply(logic [NS-1:0] pend, string tag);
        @(negedge clk);
        src_pend = pend;
        sb_q.push_back(model(pend, tag));
        #1;
        cmp_lines(last_exp, {"R9 hold before edge, ", tag});
    endtask

    task automatic drain();
        apply('0, "R9 release");
        wait (sb_q.size() == 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int n = 0; n < NS; n++) begin map_m[n] = '0; sel_m[n] = '0; end
        last_exp = model('0, "idle");
        src_pend = 5'b10101;
        repeat (3) @(posedge clk);
        #1;
        cmp_lines(model('0, "R1 during reset"), "reset");
        @(negedge clk);
        rst_n = 1'b1;
        src_pend = '0;
        #1;
        cmp_lines(model('0, "R1 first cycle after reset"), "reset");
        check_read(MAPB + 16'h0, 32'h0, "R1");
        check_read(SELB + 16'h0, 32'h0, "R1");
        check_read(SELB + 16'h84, 32'h0, "R1");

        // R2: stored field bits only.
        bus_write(MAPB + 16'h0, 32'hFFFF_FFC3);
        check_read(MAPB + 16'h0, 32'hE000_0003, "R2");
        bus_write(MAPB + 16'h0, 32'h8000_0002);
        check_read(MAPB + 16'h0, 32'h8000_0002, "R2");
        bus_write(SELB + 16'h0, 32'h0000_0005);
        check_read(SELB + 16'h0, 32'h0000_0005, "R3");
        apply(5'b00001, "R4 R7 src0 pin2 cpus 0 and 2");
        drain();

        // R4: boundary pin numbers 0 and NUM_PIN-1.
        bus_write(MAPB + 16'h0, 32'h8000_0005);
        apply(5'b00001, "R4 pin5");
        drain();
        bus_write(MAPB + 16'h0, 32'h8000_0000);
        apply(5'b00001, "R4 pin0");
        drain();

        // R3, R5: second selection word, only two live bits.
        bus_write(SELB + 16'h24, 32'hFFFF_FFFF);
        check_read(SELB + 16'h24, 32'h0000_0003, "R3");
        check_read(SELB + 16'h20, 32'h0000_0000, "R3");
        bus_write(MAPB + 16'h4, 32'h4000_0000);
        apply(5'b00010, "R5 R3 nmi cpus 32 and 33");
        drain();

        // R6: debug only, pin number set but pin disabled.
        bus_write(MAPB + 16'h8, 32'h2000_0001);
        bus_write(SELB + 16'h40, 32'h0000_0002);
        apply(5'b00100, "R6 debug cpu1");
        drain();

        // R8: out-of-range pin numbers.
        bus_write(MAPB + 16'hC, 32'hC000_0007);
        bus_write(SELB + 16'h60, 32'h0000_0008);
        bus_write(MAPB + 16'h10, 32'h8000_003F);
        bus_write(SELB + 16'h80, 32'h0000_0001);
        check_read(MAPB + 16'h10, 32'h8000_003F, "R2");
        apply(5'b01000, "R8 pin7 ignored nmi kept");
        apply(5'b10000, "R8 pin63 ignored");
        drain();

        // R7, R9: overlapping sources and back-to-back patterns.
        bus_write(SELB + 16'h80, 32'h0000_0005);
        bus_write(MAPB + 16'h10, 32'hA000_0000);
        apply(5'b11111, "R7 all sources");
        apply(5'b10001, "R7 two sources share cpu0 pin0");
        apply(5'b01010, "R9 pattern change");
        apply(5'b00100, "R9 pattern change");
        apply(5'b11111, "R7 all again");
        drain();

        // R10: stray, misaligned and out-of-range word writes.
        bus_write(MAPB + 16'h14, 32'hFFFF_FFFF);
        bus_write(16'h0800, 32'hFFFF_FFFF);
        bus_write(SELB + 16'h8, 32'hFFFF_FFFF);
        bus_write(MAPB + 16'h1, 32'h0000_0000);
        bus_write(SELB + 16'h1, 32'h0000_0000);
        check_read(MAPB + 16'h0, 32'h8000_0000, "R10");
        check_read(SELB + 16'h0, 32'h0000_0005, "R10");
        check_read(MAPB + 16'h14, 32'h0, "R10");
        check_read(16'h0800, 32'h0, "R10");
        check_read(SELB + 16'h8, 32'h0, "R10");
        check_read(MAPB + 16'h1, 32'h0, "R10");
        for (int i = 0; i < NS; i++) begin
            check_line(model_rd(MAPB + 16'(4*i)) === map_m[i], "R10 model consistency");
        end
        apply(5'b00001, "R10 routing intact after stray writes");
        drain();

        #(CLK_PERIOD * 2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule